// File: doc/BRIEF.md
# Feed-Protected Clock Control Registers

This block is the software-facing register set that sits beside a clock multiplier and its post-divider. Software writes a multiplier field, a post-divider code and enable/connect bits into shadow registers. None of these values reaches the clock hardware until software writes a two-value unlock key to a dedicated key register. The key is 0xAA followed directly by 0x55. This keeps a single stray store from retuning or switching the clock.

A status register shows what the hardware is really using. It reports the committed fields, the effective connect state and the live lock input. A separate peripheral-rate register sets a one-cycle clock-enable pulse. The pulse fires every 1, 2 or 4 CPU cycles, and downstream logic uses it to pace the peripheral side.

The bus is a plain synchronous register port. A write takes effect at the clock edge where `wr_en_i` is high. `rdata_o` is combinational on `addr_i`. `rd_en_i` marks a read access, and the unlock sequencer uses it to detect bus accesses. There is no back-pressure: every access completes in the cycle it is presented.

Top module: `clkctl_top`

Register addresses: 0 = control, 1 = configuration, 2 = status, 3 = key, 4 = peripheral rate.

## Requirements
- R1: After reset, the following are all zero: the pending and active control and configuration values, the peripheral-rate value, `pll_en_o`, `pll_connect_o`, `mult_o` and `div_code_o`. `post_div_o` reads 1, which is divide by one. Status reads zero apart from bit 10, which follows `lock_i`.
- R2: A write to control (bits [1:0]) or configuration (bits [6:0]) changes only the pending copy. Reading that address returns the pending value. The outputs and the status register keep their active values.
- R3: A key-register write of 0x55 that directly follows a key-register write of 0xAA, with no other bus access between them, copies both pending registers into the active set at that clock edge.
- R4: The sequence is abandoned, and nothing is committed, if any of these comes between 0xAA and 0x55: a read, a write to another address, or a key write of a value other than 0xAA or 0x55. A new 0xAA always restarts the sequence.
- R5: The configuration word holds the multiplier minus one in bits [4:0] and the post-divider code in bits [6:5]. Codes 0, 1, 2 and 3 give a post-divide of 1, 2, 4 and 8. `post_div_o` carries that ratio as a one-hot value.
- R6: In control, bit 0 is enable and bit 1 is connect. `pll_connect_o` is high only when the active enable bit, the active connect bit and `lock_i` are all high.
- R7: The status layout is as follows. Bits [4:0] hold the active multiplier field and bits [6:5] the active divider code. Bit 8 is active enable, bit 9 is effective connect and bit 10 is `lock_i`. All other bits read zero.
- R8: Peripheral-rate values 0, 1 and 2 give a `pclk_en_o` pulse every 4, 1 and 2 cycles respectively. The value reads back from address 4.
- R9: A write to the peripheral-rate register restarts the pulse phase. The first pulse comes in the N-th cycle after the write edge, where N is the selected period.
- R10: Peripheral-rate value 3 behaves exactly like value 0, giving a pulse every 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read access marker |
| rdata_o | output | 16 | Read data for `addr_i` |
| lock_i | input | 1 | Lock indication from the PLL |
| pll_en_o | output | 1 | Active enable to the PLL |
| pll_connect_o | output | 1 | Effective connect (clock source select) |
| mult_o | output | 5 | Active multiplier field (m-1) |
| div_code_o | output | 2 | Active post-divider code |
| post_div_o | output | 4 | One-hot post-divide ratio |
| pclk_en_o | output | 1 | Peripheral clock-enable pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit data word, a 5-bit multiplier field and a 2-bit divider code. These widths are small enough to commit every one of the 128 configuration words in turn. Each commit is checked on the outputs and in the decoded status. Every peripheral-rate code is run over several periods, and each code is rewritten part-way through a period to exercise the phase restart. The connect gating is swept over all combinations of enable, connect and lock, and each way of breaking the unlock key is tried against a pending change.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 3'd0,
    RA_CFG  = 3'd1,
    RA_STAT = 3'd2,
    RA_KEY  = 3'd3,
    RA_PDIV = 3'd4
  } reg_addr_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  localparam int ST_EN_BIT   = 8;
  localparam int ST_CON_BIT  = 9;
  localparam int ST_LOCK_BIT = 10;
endpackage

// File: rtl/clkctl_key_seq.sv
module clkctl_key_seq
  import clkctl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  output logic                  commit_o
);
  logic armed_q;
  logic key_wr;
  logic is_first;
  logic is_second;

  assign key_wr    = wr_en_i && (addr_i == RA_KEY);
  assign is_first  = (wdata_i == DATA_W'(KEY_FIRST));
  assign is_second = (wdata_i == DATA_W'(KEY_SECOND));
  assign commit_o  = armed_q && key_wr && is_second;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (key_wr && is_first) begin
      armed_q <= 1'b1;
    end else if (wr_en_i || rd_en_i) begin
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/clkctl_pclk_div.sv
module clkctl_pclk_div #(
  parameter int SEL_W = 2,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             pulse_o
);
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  always_comb begin
    case (sel_q)
      SEL_W'(1): last = CNT_W'(0);
      SEL_W'(2): last = CNT_W'(1);
      default:   last = CNT_W'(3);
    endcase
  end

  assign pulse_o = (cnt_q == last);
  assign sel_o   = sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else if (wr_i) begin
      sel_q <= sel_i;
      cnt_q <= '0;
    end else if (cnt_q == last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/clkctl_ratio_dec.sv
module clkctl_ratio_dec #(
  parameter int CODE_W = 2,
  localparam int RATIO_W = 1 << CODE_W
) (
  input  logic [CODE_W-1:0]  code_i,
  output logic [RATIO_W-1:0] ratio_o
);
  for (genvar i = 0; i < RATIO_W; i++) begin : g_bit
    assign ratio_o[i] = (code_i == CODE_W'(i));
  end
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MULT_W  = 5,
  parameter int DCODE_W = 2,
  localparam int CFG_W   = MULT_W + DCODE_W,
  localparam int RATIO_W = 1 << DCODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                lock_i,
  output logic                pll_en_o,
  output logic                pll_connect_o,
  output logic [MULT_W-1:0]   mult_o,
  output logic [DCODE_W-1:0]  div_code_o,
  output logic [RATIO_W-1:0]  post_div_o,
  output logic                pclk_en_o
);
  logic [1:0]       ctrl_sh;
  logic [CFG_W-1:0] cfg_sh;
  logic             en_q;
  logic             con_q;
  logic [CFG_W-1:0] cfg_q;
  logic             commit;
  logic [1:0]       pdiv_sel;
  logic [DATA_W-1:0] status;

  clkctl_key_seq #(.DATA_W(DATA_W)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .commit_o (commit)
  );

  clkctl_pclk_div #(.SEL_W(2), .CNT_W(2)) u_pdiv (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_en_i && (addr_i == RA_PDIV)),
    .sel_i   (wdata_i[1:0]),
    .sel_o   (pdiv_sel),
    .pulse_o (pclk_en_o)
  );

  clkctl_ratio_dec #(.CODE_W(DCODE_W)) u_ratio (
    .code_i  (div_code_o),
    .ratio_o (post_div_o)
  );

  // shadow copies take every write; active set loads only on commit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_sh <= '0;
      cfg_sh  <= '0;
      en_q    <= 1'b0;
      con_q   <= 1'b0;
      cfg_q   <= '0;
    end else begin
      if (wr_en_i && addr_i == RA_CTRL) ctrl_sh <= wdata_i[1:0];
      if (wr_en_i && addr_i == RA_CFG)  cfg_sh  <= wdata_i[CFG_W-1:0];
      if (commit) begin
        en_q  <= ctrl_sh[0];
        con_q <= ctrl_sh[1];
        cfg_q <= cfg_sh;
      end
    end
  end

  assign pll_en_o      = en_q;
  assign pll_connect_o = en_q && con_q && lock_i;
  assign mult_o        = cfg_q[MULT_W-1:0];
  assign div_code_o    = cfg_q[CFG_W-1:MULT_W];

  always_comb begin
    status = '0;
    status[CFG_W-1:0]  = cfg_q;
    status[ST_EN_BIT]  = en_q;
    status[ST_CON_BIT] = pll_connect_o;
    status[ST_LOCK_BIT] = lock_i;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL: rdata_o[1:0]       = ctrl_sh;
      RA_CFG:  rdata_o[CFG_W-1:0] = cfg_sh;
      RA_STAT: rdata_o            = status;
      RA_PDIV: rdata_o[1:0]       = pdiv_sel;
      default: rdata_o            = '0;
    endcase
  end
endmodule

// File: rtl/clkctl_checker.sv
module clkctl_checker
  import clkctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MULT_W = 5,
  parameter int CFG_W  = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               wr_en_i,
  input logic               lock_i,
  input logic               pll_en_o,
  input logic               pll_connect_o,
  input logic [MULT_W-1:0]  mult_o,
  input logic               pclk_en_o,
  input logic [1:0]         pdiv_sel,
  input logic [CFG_W-1:0]   cfg_sh
);
  logic key_wr;
  assign key_wr = wr_en_i && (addr_i == RA_KEY);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> ($stable(mult_o) && $stable(pll_en_o)));

  p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wdata_i == DATA_W'(KEY_SECOND) &&
     $past(wr_en_i && addr_i == RA_KEY && wdata_i == DATA_W'(KEY_FIRST)))
    |=> (mult_o == $past(cfg_sh[MULT_W-1:0])));

  p_badkey_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wdata_i != DATA_W'(KEY_SECOND)) |=> ($stable(mult_o) && $stable(pll_en_o)));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pll_connect_o |-> (pll_en_o && lock_i));

  p_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk_en_o && pdiv_sel != 2'd1 && !(wr_en_i && addr_i == RA_PDIV)) |=> !pclk_en_o);
endmodule

bind clkctl_top clkctl_checker #(.DATA_W(DATA_W), .MULT_W(MULT_W), .CFG_W(CFG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .wr_en_i       (wr_en_i),
  .lock_i        (lock_i),
  .pll_en_o      (pll_en_o),
  .pll_connect_o (pll_connect_o),
  .mult_o        (mult_o),
  .pclk_en_o     (pclk_en_o),
  .pdiv_sel      (pdiv_sel),
  .cfg_sh        (cfg_sh)
);

// File: tb/clkctl_top_bench.sv
module clkctl_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [15:0] rdata_o;
  logic        lock_i = 1'b0;
  logic        pll_en_o, pll_connect_o, pclk_en_o;
  logic [4:0]  mult_o;
  logic [1:0]  div_code_o;
  logic [3:0]  post_div_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clkctl_top u_clkctl_top (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o), .lock_i(lock_i),
    .pll_en_o(pll_en_o), .pll_connect_o(pll_connect_o), .mult_o(mult_o),
    .div_code_o(div_code_o), .post_div_o(post_div_o), .pclk_en_o(pclk_en_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr_i = 3'(a); wdata_i = 16'(d); wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr_i = 3'(a); rd_en_i = 1'b1;
    #1 d = int'(rdata_o);
    @(negedge clk);
    rd_en_i = 1'b0; addr_i = '0;
  endtask

  task automatic unlock();
    wr(3, 'hAA);
    wr(3, 'h55);
  endtask

  function automatic int stat_exp(int cfg, bit en, bit con, bit lk);
    return (cfg & 'h7F) | (int'(en) << 8) | (int'(en && con && lk) << 9) | (int'(lk) << 10);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v;
    int miss;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pll_en_o == 0 && pll_connect_o == 0 && mult_o == 0 && div_code_o == 0,
        "R1 outputs", {pll_en_o, pll_connect_o, mult_o, div_code_o}, 0);
    chk(post_div_o == 4'b0001, "R1 post_div", post_div_o, 1);
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      chk(v == 0, "R1 register", v, 0);
    end
    lock_i = 1'b1;
    rd(2, v);
    chk(v == 'h400, "R1 lock bit", v, 'h400);
    lock_i = 1'b0;

    // R2 pending only
    wr(1, 'h45);
    wr(0, 'h3);
    rd(1, v); chk(v == 'h45, "R2 cfg readback", v, 'h45);
    rd(0, v); chk(v == 'h3, "R2 ctrl readback", v, 3);
    chk(mult_o == 0 && pll_en_o == 0, "R2 no early effect", mult_o, 0);
    rd(2, v); chk(v == 0, "R2 status active", v, 0);

    // R3 R5 R7 sweep every configuration word
    wr(0, 'h1);
    for (int c = 0; c < 128; c++) begin
      wr(1, c);
      unlock();
      chk(mult_o == 5'(c) && div_code_o == 2'(c >> 5), "R3 commit", {div_code_o, mult_o}, c);
      chk(post_div_o == 4'(1 << (c >> 5)), "R5 ratio", post_div_o, 1 << (c >> 5));
      rd(2, v);
      chk(v == stat_exp(c, 1, 0, 0), "R7 status", v, stat_exp(c, 1, 0, 0));
    end

    // R4 broken sequences: active cfg is 0x7F now
    wr(1, 'h12);
    wr(3, 'hAA); rd(2, v); wr(3, 'h55);
    chk(mult_o == 5'h1F, "R4 read between", mult_o, 'h1F);
    wr(3, 'hAA); wr(0, 'h1); wr(3, 'h55);
    chk(mult_o == 5'h1F, "R4 other write between", mult_o, 'h1F);
    wr(3, 'hAA); wr(3, 'h56); wr(3, 'h55);
    chk(mult_o == 5'h1F, "R4 wrong key", mult_o, 'h1F);
    wr(3, 'h55);
    chk(mult_o == 5'h1F, "R4 lone second key", mult_o, 'h1F);
    wr(3, 'hAA); wr(3, 'hAA); wr(3, 'h55);
    chk(mult_o == 5'h12, "R4 restart on first key", mult_o, 'h12);

    // R6 connect gating over enable, connect, lock
    for (int k = 0; k < 4; k++) begin
      wr(0, k);
      unlock();
      for (int l = 0; l < 2; l++) begin
        lock_i = 1'(l);
        @(negedge clk);
        chk(pll_connect_o == (k == 3 && l == 1), "R6 connect", pll_connect_o, (k == 3 && l == 1));
        rd(2, v);
        chk(v == stat_exp('h12, k[0], k[1], 1'(l)), "R6 status", v, stat_exp('h12, k[0], k[1], 1'(l)));
      end
    end
    lock_i = 1'b0;

    // R8 R9 R10 peripheral rate, each code rewritten mid-period
    for (int s = 0; s < 4; s++) begin
      int per;
      per = (s == 1) ? 1 : (s == 2) ? 2 : 4;
      for (int rep = 0; rep < 2; rep++) begin
        wr(4, s);
        miss = 0;
        for (int k = 0; k < 6 + rep; k++) begin
          if (pclk_en_o != ((k % per) == per - 1)) miss++;
          if (k != 5 + rep) @(negedge clk);
        end
        chk(miss == 0, (s == 3) ? "R10 code three rate" : (rep == 0 ? "R8 rate" : "R9 phase restart"), miss, 0);
      end
      rd(4, v);
      chk(v == s, "R8 readback", v, s);
    end

    finish_run();
  end
endmodule